// File: doc/BRIEF.md
# Four-Source Vectored Interrupt Controller with Skip-Test Polling

This block arbitrates interrupts for a small 4-bit-class processor core. It has four sources: one external pin level-change event and three timer underflow pulses. Each source has a sticky request flag and an enable bit, and one global enable flag gates them all. When the core accepts an interrupt, the block picks the pending, enabled source of highest priority. It then emits a one-cycle vector pulse that carries a fixed page number and entry address.

Each source's enable bit also chooses how the core services that source. With the bit set, the source raises vectored interrupts. With the bit clear, the core polls the source with a skip-test instruction. A valid skip-test returns the flag and clears it. The enable bits are loaded by writes to two control registers. Accepting an interrupt drops the global enable, so the core must run its enable strobe again before the next interrupt can be taken.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset all request flags, enable bits and the global enable are 0, so `irq_req`, `vec_valid` and `skip_hit` are all low.
- R2: A high bit on `src_evt` sets that source's flag at the next edge, whatever the enable bits or the global enable are, and the flag holds until it is cleared. Source numbering: bit 0 is external 0, bit 1 is timer 1, bit 2 is timer 2, bit 3 is timer 3. `skip_sel` uses the same numbering.
- R3: `irq_req` is high exactly when at least one source has its flag set, its enable bit set and the global enable set.
- R4: `ei_stb` sets the global enable at the next edge and `di_stb` clears it. If both are high in the same cycle, the clear wins.
- R5: When `take_stb` is high while `irq_req` is high, `vec_valid` pulses for exactly the following cycle. During that pulse `vec_page` is 1 and `vec_addr` is the winner's entry: 0 for external 0, 4 for timer 1, 6 for timer 2, 8 for timer 3. `take_stb` while `irq_req` is low produces no pulse.
- R6: Priority runs external 0, then timer 1, then timer 2, then timer 3. Acceptance clears only the winner's flag, so other flags stay pending.
- R7: Acceptance clears the global enable at the same edge, so `irq_req` is low during the vector pulse.
- R8: The `cr1_we` strobe loads the enable bits from `cr_wdata`: bit 0 goes to external 0, bit 2 to timer 1, bit 3 to timer 2, and bit 1 is ignored. The `cr2_we` strobe loads `cr_wdata` bit 0 into the timer 3 enable.
- R9: A skip-test (`skip_stb` with `skip_sel`) is valid only while the selected source's enable bit is 0. A valid test drives `skip_hit` to the flag's current value in the same cycle and clears the flag at the edge. An invalid test keeps `skip_hit` low and leaves the flag unchanged.
- R10: If a source event arrives in the same cycle as a clear of that flag, by acceptance or by skip-test, the flag stays set.
- R11: `vec_page` and `vec_addr` read 0 whenever `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 4 | Per-source request events, one cycle each |
| ei_stb | input | 1 | Set global enable |
| di_stb | input | 1 | Clear global enable |
| take_stb | input | 1 | Core accepts the pending interrupt |
| skip_stb | input | 1 | Skip-test instruction strobe |
| skip_sel | input | 2 | Source tested by the skip-test |
| cr1_we | input | 1 | Write first enable register |
| cr2_we | input | 1 | Write second enable register |
| cr_wdata | input | 4 | Enable register write data |
| irq_req | output | 1 | An enabled interrupt is pending |
| vec_valid | output | 1 | One-cycle acceptance pulse |
| vec_page | output | 4 | Entry page during the pulse |
| vec_addr | output | 7 | Entry address during the pulse |
| skip_hit | output | 1 | Skip-test result |

## Verification
The bench raises all four flags while the global enable is off, then accepts the interrupts one by one. A wrong priority encoder returns the entries in the wrong order, and a mask that clears every flag on acceptance loses the later entries. A skip-test is issued against an enabled source to show that the test is ignored and the flag survives. A design that clears the flag anyway reads 0 once the enable is withdrawn. Same-cycle collisions between an event and a skip or an acceptance check that the set wins, and a write to the ignored bit 1 of the first enable register must enable nothing.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 7,
  parameter int VEC_PAGE = 1,
  parameter int VA_EXT0 = 0,
  parameter int VA_TMR1 = 4,
  parameter int VA_TMR2 = 6,
  parameter int VA_TMR3 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_evt,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              take_stb,
  input  logic              skip_stb,
  input  logic [1:0]        skip_sel,
  input  logic              cr1_we,
  input  logic              cr2_we,
  input  logic [3:0]        cr_wdata,
  output logic              irq_req,
  output logic              vec_valid,
  output logic [PAGE_W-1:0] vec_page,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              skip_hit
);
  logic [3:0] flg;
  logic [3:0] en;
  logic       gie;
  logic [1:0] win;
  logic [3:0] live;
  logic [3:0] clr;
  logic       take_ok, skip_ok;
  logic [ADDR_W-1:0] win_addr;

  assign live    = flg & en & {4{gie}};
  assign irq_req = |live;
  assign take_ok = take_stb & irq_req;
  assign skip_ok = skip_stb & ~en[skip_sel];
  assign skip_hit = skip_ok & flg[skip_sel];

  always_comb begin
    win = 2'd3;
    for (int i = 3; i >= 0; i--)
      if (live[i]) win = 2'(i);
  end

  always_comb begin
    case (win)
      2'd0:    win_addr = ADDR_W'(VA_EXT0);
      2'd1:    win_addr = ADDR_W'(VA_TMR1);
      2'd2:    win_addr = ADDR_W'(VA_TMR2);
      default: win_addr = ADDR_W'(VA_TMR3);
    endcase
  end

  always_comb begin
    clr = '0;
    if (take_ok) clr[win] = 1'b1;
    if (skip_ok) clr[skip_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg       <= '0;
      en        <= '0;
      gie       <= 1'b0;
      vec_valid <= 1'b0;
      vec_page  <= '0;
      vec_addr  <= '0;
    end else begin
      flg <= (flg & ~clr) | src_evt;
      if (cr1_we) begin
        en[0] <= cr_wdata[0];
        en[1] <= cr_wdata[2];
        en[2] <= cr_wdata[3];
      end
      if (cr2_we) en[3] <= cr_wdata[0];
      if (take_ok || di_stb) gie <= 1'b0;
      else if (ei_stb)       gie <= 1'b1;
      vec_valid <= take_ok;
      vec_page  <= take_ok ? PAGE_W'(VEC_PAGE) : '0;
      vec_addr  <= take_ok ? win_addr : '0;
    end
  end
endmodule

module irq_vector_unit_sva #(
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 7,
  parameter int VEC_PAGE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ei_stb,
  input logic              di_stb,
  input logic              take_stb,
  input logic              skip_stb,
  input logic              irq_req,
  input logic              vec_valid,
  input logic [PAGE_W-1:0] vec_page,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              skip_hit,
  input logic              gie
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  a_r5_no_take_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stb && !irq_req) |=> !vec_valid);
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_page == PAGE_W'(VEC_PAGE));
  a_r7_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !irq_req);
  a_r4_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    di_stb |=> !gie);
  a_r4_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !(take_stb && irq_req)) |=> gie);
  a_r3_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);
  a_r9_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |-> skip_stb);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_page == '0 && vec_addr == '0));
endmodule

bind irq_vector_unit irq_vector_unit_sva #(
  .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .VEC_PAGE(VEC_PAGE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
  .take_stb(take_stb), .skip_stb(skip_stb), .irq_req(irq_req),
  .vec_valid(vec_valid), .vec_page(vec_page), .vec_addr(vec_addr),
  .skip_hit(skip_hit), .gie(gie)
);

// File: tb/irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_evt = '0;
  logic ei_stb = 0, di_stb = 0, take_stb = 0, skip_stb = 0;
  logic [1:0] skip_sel = '0;
  logic cr1_we = 0, cr2_we = 0;
  logic [3:0] cr_wdata = '0;
  logic irq_req, vec_valid, skip_hit;
  logic [3:0] vec_page;
  logic [6:0] vec_addr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .ei_stb(ei_stb),
    .di_stb(di_stb), .take_stb(take_stb), .skip_stb(skip_stb),
    .skip_sel(skip_sel), .cr1_we(cr1_we), .cr2_we(cr2_we),
    .cr_wdata(cr_wdata), .irq_req(irq_req), .vec_valid(vec_valid),
    .vec_page(vec_page), .vec_addr(vec_addr), .skip_hit(skip_hit)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic evt(input logic [3:0] m);
    src_evt = m; tick(); src_evt = '0;
  endtask

  task automatic wr(input bit second, input logic [3:0] d);
    cr_wdata = d;
    if (second) cr2_we = 1; else cr1_we = 1;
    tick(); cr1_we = 0; cr2_we = 0;
  endtask

  task automatic ei();  ei_stb = 1; tick(); ei_stb = 0; endtask
  task automatic di();  di_stb = 1; tick(); di_stb = 0; endtask

  task automatic skip(input int sel, input int exp, input string tag,
                      input logic [3:0] ev = 4'h0);
    skip_sel = 2'(sel); skip_stb = 1; src_evt = ev; #1;
    chk(skip_hit, exp, tag);
    tick(); skip_stb = 0; src_evt = '0;
  endtask

  task automatic take(input int exp_addr, input string tag,
                      input logic [3:0] ev = 4'h0);
    take_stb = 1; src_evt = ev; tick(); take_stb = 0; src_evt = '0;
    chk(vec_valid, 1, {tag, " valid"});
    chk(vec_page, 1, {tag, " page"});
    chk(vec_addr, exp_addr, {tag, " addr"});
    chk(irq_req, 0, {tag, " R7 gie dropped"});
    tick();
    chk(vec_valid, 0, {tag, " R5 pulse ends"});
    chk(vec_addr, 0, {tag, " R11 addr idle"});
  endtask

  task automatic t_reset();
    chk(irq_req, 0, "R1 irq_req");
    chk(vec_valid, 0, "R1 vec_valid");
    for (int i = 0; i < 4; i++) skip(i, 0, "R1 flag clear");
    ei(); chk(irq_req, 0, "R1 enables clear"); di();
  endtask

  task automatic t_sticky();
    evt(4'b0001); tick(); tick();
    skip(0, 1, "R2 flag held");
    skip(0, 0, "R9 skip cleared");
    evt(4'b1000);
    skip(3, 1, "R2 timer3 flag");
  endtask

  task automatic t_global();
    wr(0, 4'b1101); wr(1, 4'b0001);
    evt(4'b0100);
    chk(irq_req, 0, "R3 gie off");
    ei(); chk(irq_req, 1, "R3 R4 pending");
    di(); chk(irq_req, 0, "R4 di");
    ei_stb = 1; di_stb = 1; tick(); ei_stb = 0; di_stb = 0;
    chk(irq_req, 0, "R4 di wins");
    ei(); take(6, "R5 timer2");
  endtask

  task automatic t_priority();
    evt(4'b1111); ei();
    take(0, "R6 ext0 first");
    ei(); take(4, "R6 timer1");
    ei(); take(6, "R6 timer2");
    ei(); take(8, "R6 timer3");
    ei(); chk(irq_req, 0, "R6 all served"); di();
  endtask

  task automatic t_no_take();
    take_stb = 1; tick(); take_stb = 0;
    chk(vec_valid, 0, "R5 take without req");
  endtask

  task automatic t_skip_invalid();
    evt(4'b0001);
    skip(0, 0, "R9 invalid while enabled");
    ei(); chk(irq_req, 1, "R9 flag untouched"); di();
    wr(0, 4'b0000);
    skip(0, 1, "R9 valid after disable");
  endtask

  task automatic t_map();
    wr(0, 4'b0010); wr(1, 4'b0000);
    evt(4'b0001); ei();
    chk(irq_req, 0, "R8 bit1 ignored");
    di(); skip(0, 1, "R8 ext0 still polled");
    wr(0, 4'b0100);
    evt(4'b0110); ei();
    take(4, "R8 timer1 bit2");
    skip(2, 1, "R8 timer2 disabled");
    wr(1, 4'b0001); evt(4'b1000); ei();
    take(8, "R8 timer3 cr2");
    wr(1, 4'b0000);
  endtask

  task automatic t_collide();
    wr(0, 4'b0000);
    evt(4'b0001);
    skip(0, 1, "R10 skip with event", 4'b0001);
    skip(0, 1, "R10 flag survived");
    skip(0, 0, "R10 then cleared");
    wr(0, 4'b0100);
    evt(4'b0010); ei();
    take(4, "R10 take with event", 4'b0010);
    ei(); chk(irq_req, 1, "R10 flag kept");
    take(4, "R10 second entry");
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_sticky();
    t_global();
    t_priority();
    t_no_take();
    t_skip_invalid();
    t_map();
    t_collide();
    tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule